// File: doc/BRIEF.md
# Booth Kernel Multiply-Accumulate Unit

This unit forms the weighted sum of one 3x3 convolution window. On each accepted beat it multiplies a signed 32-bit sample by a signed 7-bit kernel weight. The weight is the recoded operand: radix-4 Booth recoding of the seven weight bits gives four signed digits and therefore four partial products. A four-operand adder built from a ripple chain of 4:2 compressor cells reduces those partial products to one 39-bit product. The product is then added into a 43-bit running sum.

A window starts on the beat that carries the start flag, or on the first beat after the previous window closed. The ninth beat of a window closes it. In the cycle after that beat, the unit raises a one-cycle done pulse and the sum output holds the complete window result. Feeding samples and weights in window order is the caller's job. The unit keeps no image data.

Top module: `booth_kernel_mac`

## Requirements
- R1: One cycle after a beat with `in_valid` high, `prod_out` equals the two's-complement product of `in_data` and `in_coef`, both read as signed, as a 39-bit signed value.
- R2: The product is exact at the corners of the operand ranges: weight -64 (0x40), weight +63 (0x3F), sample -2^31 (0x80000000) and sample 2^31-1.
- R3: A weight of zero, or a sample of zero, gives a product of zero and leaves the running sum unchanged apart from a zero addend.
- R4: A beat with `in_first` high discards the previous running sum. One cycle later `acc_out` equals that beat's product, sign-extended to 43 bits.
- R5: A beat inside an open window adds its sign-extended product to `acc_out`.
- R6: `win_done` is high for exactly one cycle, in the cycle after the ninth beat counted from the window start. In that cycle `acc_out` holds the sum of those nine products.
- R7: While `in_valid` is low, `prod_out` and `acc_out` hold their values and `win_done` stays low. `in_first`, `in_data` and `in_coef` are ignored.
- R8: The first valid beat after a window has closed starts a new window even when `in_first` is low.
- R9: A beat with `in_first` high in the middle of a window restarts the beat count. The next done pulse follows the ninth beat counted from that restart.
- R10: While `rst_n` is low, `prod_out` and `acc_out` are zero, `win_done` is low and no window is open.
- R11: Nine products of the largest magnitude, each (-2^31)*(-64) = 2^37 or each (-2^31)*63, accumulate without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample and weight are present this cycle |
| in_first | input | 1 | This beat opens a new window |
| in_data | input | 32 | Signed sample (multiplicand) |
| in_coef | input | 7 | Signed kernel weight (Booth-recoded operand) |
| prod_out | output | 39 | Signed product of the last accepted beat |
| acc_out | output | 43 | Signed running sum of the current window |
| win_done | output | 1 | One-cycle pulse: the window sum is complete |

## Verification
Two functions can meet in one cycle: the close of one window and the start of the next. While `win_done` is high for the finished window, the next beat may already be driven, either with `in_first` high or with it low, which relies on the automatic restart. The bench feeds windows back to back with no idle cycle between them. It checks that the done cycle still shows the complete nine-product sum. It then checks that the sum on the following cycle holds only the new beat's product, with no residue from the closed window.

// File: rtl/booth_mac_pkg.sv
// Package: shared types and the radix-4 digit decoder for the kernel MAC.
// Assumes a three-bit recoding group {upper, middle, lower}, where the
// lower bit is the upper bit of the next less significant group (or the
// implicit zero below bit 0).
package booth_mac_pkg;

    localparam int DATA_W_DEF = 32;
    localparam int COEF_W_DEF = 7;
    localparam int TAPS_DEF   = 9;

    typedef enum logic [2:0] {
        DIG_ZERO = 3'd0,
        DIG_POS1 = 3'd1,
        DIG_POS2 = 3'd2,
        DIG_NEG1 = 3'd3,
        DIG_NEG2 = 3'd4
    } booth_digit_e;

    // Map one overlapping group to its signed digit.
    function automatic booth_digit_e decode_group(input logic [2:0] grp);
        booth_digit_e dig;
        unique case (grp)
            3'b001, 3'b010: dig = DIG_POS1;
            3'b011:         dig = DIG_POS2;
            3'b100:         dig = DIG_NEG2;
            3'b101, 3'b110: dig = DIG_NEG1;
            default:        dig = DIG_ZERO;
        endcase
        return dig;
    endfunction

endpackage

// File: rtl/booth_pp_sel.sv
// Module: one partial-product selector.
// Produces a body one bit wider than the multiplicand: 0, +x, +2x, ~x or
// ~(2x). For negative digits the +1 of two's-complement negation is not
// added here. It leaves on neg_bit and is added at the digit's weight
// further down. This keeps -2 * (-2^31) representable in the narrow body.
module booth_pp_sel
    import booth_mac_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [DATA_W-1:0] mcand,
    input  logic [2:0]        grp,
    output logic [DATA_W:0]   pp_body,
    output logic              neg_bit
);

    logic [DATA_W:0] mcand_x1;
    logic [DATA_W:0] mcand_x2;
    booth_digit_e    digit;

    // Candidate magnitudes and the decoded digit.
    always_comb begin
        mcand_x1 = {mcand[DATA_W-1], mcand};
        mcand_x2 = {mcand, 1'b0};
        digit    = decode_group(grp);
    end

    // Multiplexer that picks the body and the deferred negation bit.
    always_comb begin
        pp_body = '0;
        neg_bit = 1'b0;
        case (digit)
            DIG_POS1: pp_body = mcand_x1;
            DIG_POS2: pp_body = mcand_x2;
            DIG_NEG1: begin
                pp_body = ~mcand_x1;
                neg_bit = 1'b1;
            end
            DIG_NEG2: begin
                pp_body = ~mcand_x2;
                neg_bit = 1'b1;
            end
            default: begin
                pp_body = '0;
                neg_bit = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/compressor_4to2.sv
// Module: single-bit 4:2 compressor cell.
// Five inputs of equal weight; sum keeps that weight, carry and cout both
// carry double weight. cout depends only on b0..b2, so it may feed the
// next cell's cin without forming a long combinational loop.
module compressor_4to2 (
    input  logic b0,
    input  logic b1,
    input  logic b2,
    input  logic b3,
    input  logic cin,
    output logic sum,
    output logic carry,
    output logic cout
);

    logic mid;

    // First full-adder stage over three operand bits.
    always_comb begin
        mid  = b0 ^ b1 ^ b2;
        cout = (b0 & b1) | (b0 & b2) | (b1 & b2);
    end

    // Second full-adder stage with the fourth bit and the incoming carry.
    always_comb begin
        sum   = mid ^ b3 ^ cin;
        carry = (mid & b3) | (mid & cin) | (b3 & cin);
    end

endmodule

// File: rtl/four_operand_adder.sv
// Module: modulo-2^W adder of four operands plus a sparse correction row.
// A ripple of 4:2 compressors, one per bit, turns the four operands into a
// sum row and a carry row. A final carry-propagate add merges those rows
// with the correction row (the deferred negation bits). The top bit needs
// only its parity, so it uses a reduced cell and no carries leave the
// word.
module four_operand_adder #(
    parameter int W = 39
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic [W-1:0] op_d,
    input  logic [W-1:0] inject,
    output logic [W-1:0] total
);

    logic [W-1:0] sum_row;
    logic [W-1:0] carry_row;
    logic [W-1:0] chain;

    assign chain[0]     = 1'b0;
    assign carry_row[0] = 1'b0;

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i == W - 1) begin : g_top
                // Top position: only the sum bit lies inside the word.
                assign sum_row[i] = op_a[i] ^ op_b[i] ^ op_c[i] ^ op_d[i] ^ chain[i];
            end else begin : g_cell
                compressor_4to2 u_cmp (
                    .b0    (op_a[i]),
                    .b1    (op_b[i]),
                    .b2    (op_c[i]),
                    .b3    (op_d[i]),
                    .cin   (chain[i]),
                    .sum   (sum_row[i]),
                    .carry (carry_row[i+1]),
                    .cout  (chain[i+1])
                );
            end
        end
    endgenerate

    // Final carry-propagate merge of the redundant rows.
    always_comb begin
        total = sum_row + carry_row + inject;
    end

endmodule

// File: rtl/booth_multiplier.sv
// Module: combinational signed multiplier, multiplicand x Booth-recoded
// operand. Assumes COEF_W is 7 or 8, so that recoding yields exactly four
// digits for the four-operand adder. Each body is sign-extended and shifted
// by two bits per digit only here, at the summation stage.
module booth_multiplier
    import booth_mac_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int COEF_W = COEF_W_DEF
) (
    input  logic [DATA_W-1:0]        mcand,
    input  logic [COEF_W-1:0]        mplier,
    output logic [DATA_W+COEF_W-1:0] product
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int NUM_PP = (COEF_W + 1) / 2;
    localparam int PAD_W  = 2 * NUM_PP + 1;
    localparam int SEXT_W = PROD_W - DATA_W - 1;

    logic [PAD_W-1:0]  mplier_pad;
    logic [DATA_W:0]   body   [NUM_PP];
    logic              neg    [NUM_PP];
    logic [PROD_W-1:0] placed [NUM_PP];
    logic [PROD_W-1:0] neg_row;

    // Recoding operand: sign-extended on top, implicit zero at the bottom.
    always_comb begin
        mplier_pad = {{(PAD_W - COEF_W - 1){mplier[COEF_W-1]}}, mplier, 1'b0};
    end

    generate
        for (genvar k = 0; k < NUM_PP; k++) begin : g_pp
            booth_pp_sel #(.DATA_W(DATA_W)) u_sel (
                .mcand   (mcand),
                .grp     (mplier_pad[2*k+2 : 2*k]),
                .pp_body (body[k]),
                .neg_bit (neg[k])
            );
            // Sign extension and alignment to weight 4^k.
            assign placed[k] = {{SEXT_W{body[k][DATA_W]}}, body[k]} << (2 * k);
        end
    endgenerate

    // Deferred +1 of each negated digit, placed at bit 2k.
    always_comb begin
        neg_row = '0;
        for (int k = 0; k < NUM_PP; k++) begin
            neg_row[2*k] = neg[k];
        end
    end

    four_operand_adder #(.W(PROD_W)) u_add (
        .op_a   (placed[0]),
        .op_b   (placed[1]),
        .op_c   (placed[2]),
        .op_d   (placed[3]),
        .inject (neg_row),
        .total  (product)
    );

endmodule

// File: rtl/tap_accumulator.sv
// Module: window accumulator with a beat counter.
// A window opens on a first-flagged beat or on any beat while no window is
// open. It closes on its TAPS-th beat, which registers a one-cycle done
// pulse. ACC_W must exceed PROD_W.
module tap_accumulator #(
    parameter int PROD_W = 39,
    parameter int ACC_W  = 43,
    parameter int TAPS   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic [PROD_W-1:0] product,
    output logic [PROD_W-1:0] prod_q,
    output logic [ACC_W-1:0]  acc_q,
    output logic              done_q
);

    localparam int CNT_W = $clog2(TAPS + 1);
    localparam int EXT_W = ACC_W - PROD_W;

    logic [CNT_W-1:0] tap_cnt;
    logic [CNT_W-1:0] tap_next;
    logic             win_start;
    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_base;

    // Window-open decision, next count and the addend.
    always_comb begin
        win_start = in_first || (tap_cnt == '0);
        tap_next  = win_start ? CNT_W'(1) : tap_cnt + CNT_W'(1);
        prod_ext  = {{EXT_W{product[PROD_W-1]}}, product};
        acc_base  = win_start ? '0 : acc_q;
    end

    // Register the product, the sum, the count and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            acc_q   <= '0;
            done_q  <= 1'b0;
            tap_cnt <= '0;
        end else if (in_valid) begin
            prod_q  <= product;
            acc_q   <= acc_base + prod_ext;
            done_q  <= (tap_next == CNT_W'(TAPS));
            tap_cnt <= (tap_next == CNT_W'(TAPS)) ? '0 : tap_next;
        end else begin
            done_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/booth_kernel_mac.sv
// Module: top of the kernel multiply-accumulate unit.
// The combinational Booth multiplier feeds one register stage that holds
// the product, the window sum and the done pulse. The sum width leaves
// ceil(log2(TAPS)) guard bits above the product width.
module booth_kernel_mac
    import booth_mac_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int COEF_W = COEF_W_DEF,
    parameter int TAPS   = TAPS_DEF
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     in_valid,
    input  logic                                     in_first,
    input  logic [DATA_W-1:0]                        in_data,
    input  logic [COEF_W-1:0]                        in_coef,
    output logic [DATA_W+COEF_W-1:0]                 prod_out,
    output logic [DATA_W+COEF_W+$clog2(TAPS)-1:0]    acc_out,
    output logic                                     win_done
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAPS);

    logic [PROD_W-1:0] mult_q;

    booth_multiplier #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W)
    ) u_mult (
        .mcand   (in_data),
        .mplier  (in_coef),
        .product (mult_q)
    );

    tap_accumulator #(
        .PROD_W (PROD_W),
        .ACC_W  (ACC_W),
        .TAPS   (TAPS)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .product  (mult_q),
        .prod_q   (prod_out),
        .acc_q    (acc_out),
        .done_q   (win_done)
    );

endmodule

// File: rtl/booth_kernel_mac_chk.sv
// Module: port-level property checker for booth_kernel_mac, bound below.
// Keeps its own beat counter to know where each window stands.
module booth_kernel_mac_chk #(
    parameter int DATA_W = 32,
    parameter int COEF_W = 7,
    parameter int TAPS   = 9
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  in_valid,
    input logic                                  in_first,
    input logic [DATA_W-1:0]                     in_data,
    input logic [COEF_W-1:0]                     in_coef,
    input logic [DATA_W+COEF_W-1:0]              prod_out,
    input logic [DATA_W+COEF_W+$clog2(TAPS)-1:0] acc_out,
    input logic                                  win_done
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam int ACC_W  = PROD_W + $clog2(TAPS);
    localparam int CNT_W  = $clog2(TAPS + 1);

    logic [CNT_W-1:0]  seen;
    logic [CNT_W-1:0]  seen_next;
    logic              opens;
    logic [PROD_W-1:0] ref_prod;
    logic [ACC_W-1:0]  prod_sx;

    // Reference product and the checker's view of the window position.
    always_comb begin
        ref_prod  = PROD_W'($signed(in_data)) * PROD_W'($signed(in_coef));
        opens     = in_first || (seen == '0);
        seen_next = opens ? CNT_W'(1) : seen + CNT_W'(1);
        prod_sx   = {{(ACC_W - PROD_W){prod_out[PROD_W-1]}}, prod_out};
    end

    // Beat counter of the checker.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (in_valid)
            seen <= (seen_next == CNT_W'(TAPS)) ? '0 : seen_next;
    end

    a_r1_product: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod_out == $past(ref_prod));

    a_r4_first_clears: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_first |=> acc_out == prod_sx);

    a_r8_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_first && seen == '0 |=> acc_out == prod_sx);

    a_r5_accumulates: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !opens |=> acc_out == $past(acc_out) + prod_sx);

    a_r6_done_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && seen_next == CNT_W'(TAPS) |=> win_done);

    a_r6_done_only_last: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && seen_next == CNT_W'(TAPS)) |=> !win_done);

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_out) && $stable(prod_out));

endmodule

bind booth_kernel_mac booth_kernel_mac_chk #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_first (in_first),
    .in_data  (in_data),
    .in_coef  (in_coef),
    .prod_out (prod_out),
    .acc_out  (acc_out),
    .win_done (win_done)
);

// File: tb/tb_booth_kernel_mac.sv
`timescale 1ns/1ps
module tb_booth_kernel_mac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_first = 1'b0;
    logic [31:0] in_data = '0;
    logic [6:0]  in_coef = '0;
    logic [38:0] prod_out;
    logic [42:0] acc_out;
    logic        win_done;

    int     checks = 0;
    int     failures = 0;
    bit     finished = 1'b0;
    longint ref_acc = 0;
    int     ref_cnt = 0;
    logic   exp_done = 1'b0;

    // Vector format: {first, weight[6:0], sample[31:0]}
    localparam logic [39:0] VEC [0:11] = '{
        {1'b1, 7'h03, 32'd1000},
        {1'b0, 7'h7F, 32'hFFFFFF9C},
        {1'b0, 7'h2A, 32'h12345678},
        {1'b0, 7'h55, 32'h87654321},
        {1'b0, 7'h00, 32'hDEADBEEF},
        {1'b0, 7'h40, 32'h7FFFFFFF},
        {1'b0, 7'h3F, 32'h80000000},
        {1'b0, 7'h19, 32'h0000ABCD},
        {1'b0, 7'h66, 32'hFFFF0001},
        {1'b1, 7'h01, 32'd7},
        {1'b0, 7'h02, 32'd9},
        {1'b0, 7'h12, 32'hFFFFFFF0}
    };

    always #2 clk = ~clk;

    booth_kernel_mac dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_first (in_first),
        .in_data  (in_data),
        .in_coef  (in_coef),
        .prod_out (prod_out),
        .acc_out  (acc_out),
        .win_done (win_done)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One accepted beat: drive, update the reference model, sample after the edge.
    task automatic beat(input logic first, input logic [6:0] coef, input logic [31:0] data,
                        input string ptag);
        longint p;
        bit     opens;
        @(negedge clk);
        in_valid = 1'b1;
        in_first = first;
        in_coef  = coef;
        in_data  = data;
        p        = longint'($signed(data)) * longint'($signed(coef));
        opens    = first || (ref_cnt == 0);
        ref_acc  = opens ? p : ref_acc + p;
        ref_cnt  = opens ? 1 : ref_cnt + 1;
        exp_done = (ref_cnt == 9);
        if (exp_done) ref_cnt = 0;
        @(posedge clk);
        #1;
        check(ptag, 64'(prod_out), 64'(p[38:0]));
        check(opens ? "R4 window sum" : "R5 window sum", 64'(acc_out), 64'(ref_acc[42:0]));
        check("R6 done flag", 64'(win_done), 64'(exp_done));
    endtask

    // Idle cycle with noise on the ignored inputs.
    task automatic idle_check();
        logic [38:0] p_before;
        logic [42:0] a_before;
        p_before = prod_out;
        a_before = acc_out;
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b1;
        in_coef  = 7'h55;
        in_data  = 32'hA5A5A5A5;
        @(posedge clk);
        #1;
        check("R7 product hold", 64'(prod_out), 64'(p_before));
        check("R7 sum hold", 64'(acc_out), 64'(a_before));
        check("R7 done low", 64'(win_done), 64'd0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            failures++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        check("R10 product reset", 64'(prod_out), 64'd0);
        check("R10 sum reset", 64'(acc_out), 64'd0);
        check("R10 done reset", 64'(win_done), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk (R1, R3 via the zero weight); entry 9 lands on the done cycle.
        for (int i = 0; i < 12; i++) begin
            beat(VEC[i][39], VEC[i][38:32], VEC[i][31:0], "R1 product");
        end

        // R7: idle cycles hold outputs
        idle_check();
        idle_check();

        // R3: zero sample and zero weight
        beat(1'b1, 7'h15, 32'd123456, "R1 product");
        beat(1'b0, 7'h2B, 32'd0, "R3 zero sample");
        beat(1'b0, 7'h00, 32'h7FFFFFFF, "R3 zero weight");

        // R2 / R11: full-magnitude window, restarted mid-window (R9)
        beat(1'b1, 7'h40, 32'h80000000, "R2 corner -64 x min");
        for (int i = 0; i < 9; i++) begin
            beat(1'b0, 7'h40, 32'h80000000, "R11 max product");
        end
        // Next window opens with no first flag on the done cycle (R8)
        for (int i = 0; i < 9; i++) begin
            beat(1'b0, 7'h3F, 32'h80000000, "R8 R11 negative max");
        end
        beat(1'b1, 7'h40, 32'h7FFFFFFF, "R2 corner -64 x max");
        beat(1'b0, 7'h3F, 32'h7FFFFFFF, "R2 corner 63 x max");
        beat(1'b1, 7'h3F, 32'h80000000, "R9 restart");
        for (int i = 0; i < 8; i++) begin
            beat(1'b0, 7'(i * 13 + 5), 32'(i * 32'h1F3D5B79), "R9 product");
        end

        // R10: reset in the middle of a window
        beat(1'b1, 7'h11, 32'd55, "R1 product");
        @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b0;
        @(posedge clk);
        #1;
        check("R10 product after reset", 64'(prod_out), 64'd0);
        check("R10 sum after reset", 64'(acc_out), 64'd0);
        check("R10 done after reset", 64'(win_done), 64'd0);
        @(negedge clk);
        rst_n   = 1'b1;
        ref_cnt = 0;
        beat(1'b0, 7'h7E, 32'd1000, "R8 window after reset");

        @(negedge clk);
        in_valid = 1'b0;
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule